// File: doc/BRIEF.md
# Display Controller Reset-Initialization Sequencer

This block brings a character/graphics display controller into a known state after power-on or an external reset. While the reset input is high it forces a bank of eight 8-bit control registers to their default values. It also clears the address counter and raises a busy flag. Once the synchronized reset falls, a sweep fills every location of the display data RAM with the space code 0x20, one location per clock. The busy flag stays high until both the sweep and a fixed hold window of `HOLD_CYCLES` clocks have finished.

While busy, the host interface refuses everything. Instruction writes do not touch the register bank or the address counter, and data writes never reach the RAM port. The host polls a status byte that carries the busy flag and the address counter. Once ready, the host loads registers, loads the address counter, and writes display data through the same RAM port the sweep used.

The controller is a three-state machine. SWEEP is the reset and clearing state. TAIL waits out the rest of the hold window after the sweep has finished. READY accepts host traffic. The named transitions are:
- RESET: from any state to SWEEP, taken asynchronously on reset.
- SWEEP_TO_TAIL: the last RAM location is written while the hold window still has time left.
- SWEEP_TO_READY: the last location is written in or after the final hold cycle.
- TAIL_TO_READY: the hold window ends.

Top module: `dispinit_seq`

## Requirements
- R1: `busy` is 1, and status bit 7 reads 1, at any time `rst_in` is high. This takes effect without waiting for a clock edge.
- R2: `rst_in` is synchronized through two flops. With `RAM_DEPTH` ≤ `HOLD_CYCLES`, `busy` reads 1 after each of the first `HOLD_CYCLES`+1 rising edges that follow the fall of `rst_in`, and reads 0 after edge `HOLD_CYCLES`+2. With a deeper RAM, busy ends when the sweep ends.
- R3: After the second rising edge that follows the fall of `rst_in`, the sweep presents `ram_we`=1 with data 0x20. It covers addresses 0 to `RAM_DEPTH`-1 in ascending order, one per clock, each exactly once.
- R4: While `busy` is 1, host writes have no effect. Instruction writes leave `reg_bank` and the address counter unchanged. Data writes produce no RAM write and no address counter change.
- R5: The address counter is 0 when `busy` falls. A status read (`host_rd`=1, `host_rs`=0) returns {busy, address counter in bits 6:0}. Any other case returns 0.
- R6: Reset loads the defaults below, with register k at `reg_bank[8k+7:8k]`. All other register bits reset to 0, so `reg_bank` = 0x0000000000008001.
  - Register 0, entry mode: bit 0 is increment (1), bit 1 is graphics mode (0), bit 2 is the character ROM bank (0).
  - Register 1, display: bit 0 display on, bit 1 cursor, bit 2 blink, bit 3 line cursor, bit 4 centring, bits 7:5 duty (100).
  - Register 2: power amplifier, sleep, standby, a 2-bit boost field and a 3-bit bias field.
  - Register 3: 5-bit contrast.
  - Registers 4 and 5: vertical scroll, and horizontal scroll with double height.
  - Register 6: bit 0 key interrupt enable, bits 2:1 key cycle.
  - Register 7: 3-bit port level.
- R7: When ready, an instruction write (`host_wr`=1, `host_rs`=0) acts on `host_idx`:
  - 0 to 7 loads `host_wdata` into that register.
  - 8 loads the address counter from `host_wdata[6:0]`.
  - 9 to 15 change nothing.
- R8: When ready, a data write (`host_wr`=1, `host_rs`=1) writes `host_wdata` to RAM at the address counter. The counter then steps +1 if register 0 bit 0 is 1, or -1 if it is 0. It wraps between 0 and `RAM_DEPTH`-1.
- R9: Raising `rst_in` in the middle of a sweep restores all defaults and restarts the full sequence, including a complete sweep and hold window.
- R10: A host write held steady across the end of busy is accepted on the first cycle in which `busy` reads 0, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | External reset, active high, asynchronous |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rs | input | 1 | 0 = instruction/status, 1 = display data |
| host_idx | input | 4 | Instruction target: register 0-7, 8 = address counter |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Status byte {busy, address counter} |
| busy | output | 1 | Initialization in progress |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | 7 | Display RAM address |
| ram_wdata | output | 8 | Display RAM write data |
| reg_bank | output | 64 | Eight control registers, register k at bits 8k+7:8k |

## Verification
The end of the busy window and a host write can fall in the same cycle, because the write gate opens exactly when busy drops. The bench holds an instruction write, and later a data write of 0x77, steady through the whole busy interval and across its end. In the first cycle that busy reads 0, it expects the RAM port to carry the host write at address 0. Before that cycle it expects the port to carry only space-code writes and the register bank to keep its defaults. Afterwards the address counter must read 1, which shows exactly one write was accepted.

// File: rtl/dispinit_pkg.sv
package dispinit_pkg;

    localparam int REG_W       = 8;
    localparam int NUM_REGS    = 8;
    localparam logic [7:0] SPACE_CODE = 8'h20;

    typedef enum logic [1:0] {
        ST_SWEEP = 2'd0,
        ST_TAIL  = 2'd1,
        ST_READY = 2'd2
    } init_state_e;

    // Default value of each control register after reset
    function automatic logic [REG_W-1:0] reg_default(input int unsigned idx);
        case (idx)
            0:       return 8'h01;   // entry mode: increment, char mode, ROM bank 0
            1:       return 8'h80;   // display: off, duty field = 100
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/dispinit_rst_sync.sv
module dispinit_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_s
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b0};
        end
    end

    assign rst_s = chain[STAGES-1];
endmodule

// File: rtl/dispinit_regbank.sv
module dispinit_regbank
    import dispinit_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic                   rst_s,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [REG_W-1:0]       wr_data,
    output logic [NREGS*REG_W-1:0] bank
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk or posedge rst_s) begin
            if (rst_s) begin
                bank[g*REG_W +: REG_W] <= reg_default(g);
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                bank[g*REG_W +: REG_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dispinit_fsm.sv
module dispinit_fsm
    import dispinit_pkg::*;
#(
    parameter int DEPTH = 80,
    parameter int HOLD  = 1000,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(HOLD + 1)
) (
    input  logic              clk,
    input  logic              rst_s,
    output logic              busy,
    output logic              sweep_we,
    output logic [ADDR_W-1:0] sweep_addr
);
    localparam logic [ADDR_W-1:0] SWEEP_LAST = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  HOLD_LAST  = CNT_W'(HOLD - 1);
    localparam logic [CNT_W-1:0]  HOLD_SAT   = CNT_W'(HOLD);

    init_state_e      state, state_nx;
    logic [CNT_W-1:0] hold_cnt;
    logic             hold_last;

    assign hold_last = (hold_cnt >= HOLD_LAST);

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SWEEP: if (sweep_addr == SWEEP_LAST)
                          state_nx = hold_last ? ST_READY : ST_TAIL;
            ST_TAIL:  if (hold_last) state_nx = ST_READY;
            ST_READY: state_nx = ST_READY;
            default:  state_nx = ST_SWEEP;
        endcase
    end

    // state register with hold and sweep counters
    always_ff @(posedge clk or posedge rst_s) begin
        if (rst_s) begin
            state      <= ST_SWEEP;
            hold_cnt   <= '0;
            sweep_addr <= '0;
        end else begin
            state <= state_nx;
            if (state != ST_READY && hold_cnt != HOLD_SAT)
                hold_cnt <= hold_cnt + 1'b1;
            if (state == ST_SWEEP && sweep_addr != SWEEP_LAST)
                sweep_addr <= sweep_addr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = rst_s || (state != ST_READY);
        sweep_we = !rst_s && (state == ST_SWEEP);
    end
endmodule

// File: rtl/dispinit_seq.sv
module dispinit_seq
    import dispinit_pkg::*;
#(
    parameter int RAM_DEPTH   = 80,
    parameter int HOLD_CYCLES = 1000,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(RAM_DEPTH),
    localparam int IDX_W  = $clog2(NUM_REGS + 1),
    localparam int SEL_W  = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_in,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic                      host_rs,
    input  logic [IDX_W-1:0]          host_idx,
    input  logic [7:0]                host_wdata,
    output logic [7:0]                host_rdata,
    output logic                      busy,
    output logic                      ram_we,
    output logic [ADDR_W-1:0]         ram_addr,
    output logic [7:0]                ram_wdata,
    output logic [NUM_REGS*REG_W-1:0] reg_bank
);
    localparam logic [ADDR_W-1:0] AC_LAST = ADDR_W'(RAM_DEPTH - 1);

    logic              rst_s;
    logic              sweep_we;
    logic [ADDR_W-1:0] sweep_addr;
    logic [ADDR_W-1:0] ac, ac_step;
    logic              instr_we, ac_load, data_we;

    dispinit_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_in(rst_in), .rst_s(rst_s)
    );

    dispinit_fsm #(.DEPTH(RAM_DEPTH), .HOLD(HOLD_CYCLES)) u_fsm (
        .clk(clk), .rst_s(rst_s), .busy(busy),
        .sweep_we(sweep_we), .sweep_addr(sweep_addr)
    );

    // host decode, gated by busy
    always_comb begin
        instr_we = host_wr && !host_rs && !busy && (host_idx < IDX_W'(NUM_REGS));
        ac_load  = host_wr && !host_rs && !busy && (host_idx == IDX_W'(NUM_REGS));
        data_we  = host_wr &&  host_rs && !busy;
    end

    dispinit_regbank #(.NREGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_s(rst_s), .wr_en(instr_we),
        .wr_sel(host_idx[SEL_W-1:0]), .wr_data(host_wdata), .bank(reg_bank)
    );

    // address counter step follows entry-mode bit 0
    always_comb begin
        if (reg_bank[0]) ac_step = (ac == AC_LAST) ? '0 : ac + 1'b1;
        else             ac_step = (ac == '0) ? AC_LAST : ac - 1'b1;
    end

    always_ff @(posedge clk or posedge rst_s) begin
        if (rst_s)        ac <= '0;
        else if (ac_load) ac <= host_wdata[ADDR_W-1:0];
        else if (data_we) ac <= ac_step;
    end

    // shared RAM port: sweep while busy, host afterwards
    always_comb begin
        ram_we    = sweep_we || data_we;
        ram_addr  = sweep_we ? sweep_addr : ac;
        ram_wdata = sweep_we ? SPACE_CODE : host_wdata;
    end

    assign host_rdata = (host_rd && !host_rs) ? {busy, 7'(ac)} : 8'h00;
endmodule

// File: rtl/dispinit_seq_chk.sv
module dispinit_seq_chk #(
    parameter int DEPTH  = 80,
    parameter int HOLD   = 1000,
    parameter int ADDR_W = 7,
    parameter int BANK_W = 64,
    localparam int FINISH = (DEPTH > HOLD) ? DEPTH : HOLD,
    localparam int CW     = $clog2(FINISH + 1)
) (
    input logic              clk,
    input logic              rst_in,
    input logic              rst_s,
    input logic              busy,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [7:0]        ram_wdata,
    input logic [ADDR_W-1:0] ac,
    input logic [BANK_W-1:0] reg_bank
);
    logic [CW-1:0] rel_cnt;

    always_ff @(posedge clk or posedge rst_s) begin
        if (rst_s)                          rel_cnt <= '0;
        else if (rel_cnt != CW'(FINISH))    rel_cnt <= rel_cnt + 1'b1;
    end

    a_r1_busy_in_reset: assert property (@(posedge clk) rst_in |-> busy);

    a_r2_hold_window: assert property (@(posedge clk) disable iff (rst_s)
        (rel_cnt < CW'(HOLD)) |-> busy);

    a_r2_busy_ends: assert property (@(posedge clk) disable iff (rst_s)
        (rel_cnt >= CW'(FINISH)) |-> !busy);

    a_r3_sweep_space: assert property (@(posedge clk) disable iff (rst_s)
        (busy && ram_we) |-> (ram_wdata == 8'h20));

    a_r3_sweep_step: assert property (@(posedge clk) disable iff (rst_s)
        (busy && ram_we && $past(busy && ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1));

    a_r4_regs_frozen: assert property (@(posedge clk) disable iff (rst_s)
        busy |=> $stable(reg_bank));

    a_r5_ac_zero_at_ready: assert property (@(posedge clk) disable iff (rst_s)
        $fell(busy) |-> (ac == '0));
endmodule

bind dispinit_seq dispinit_seq_chk #(
    .DEPTH(RAM_DEPTH), .HOLD(HOLD_CYCLES), .ADDR_W(ADDR_W), .BANK_W(NUM_REGS*REG_W)
) chk_i (
    .clk(clk), .rst_in(rst_in), .rst_s(rst_s), .busy(busy),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ac(ac), .reg_bank(reg_bank)
);

// File: tb/dispinit_seq_tb_top.sv
`timescale 1ns/1ps
module dispinit_seq_tb_top;
    localparam int DEPTH = 80;
    localparam int HOLD  = 1000;
    localparam logic [63:0] BANK_DEF = 64'h0000000000008001;

    logic        clk = 1'b0;
    logic        rst_in = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0, host_rs = 1'b0;
    logic [3:0]  host_idx = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        busy, ram_we;
    logic [6:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [63:0] reg_bank;

    always #2.5 clk = ~clk;

    dispinit_seq #(.RAM_DEPTH(DEPTH), .HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst_in(rst_in), .host_wr(host_wr), .host_rd(host_rd),
        .host_rs(host_rs), .host_idx(host_idx), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .reg_bank(reg_bank)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // RAM model and write accounting
    logic [7:0] ram_model [DEPTH];
    int sweep_wr_cnt = 0;
    int bad_busy_wr  = 0;

    always @(posedge clk) begin
        if (ram_we === 1'b1) begin
            ram_model[ram_addr] <= ram_wdata;
            if (busy === 1'b1) begin
                if (ram_wdata == 8'h20) sweep_wr_cnt++;
                else                    bad_busy_wr++;
            end
        end
    end

    // {kind, idx, data, expected address counter}; kind 0 = instruction, 1 = data
    localparam logic [20:0] VEC [12] = '{
        {2'd1, 4'd0, 8'h41, 7'd2},
        {2'd0, 4'd8, 8'h00, 7'd0},
        {2'd1, 4'd0, 8'h42, 7'd1},
        {2'd0, 4'd8, 8'h4E, 7'd78},
        {2'd1, 4'd0, 8'h43, 7'd79},
        {2'd1, 4'd0, 8'h44, 7'd0},
        {2'd0, 4'd0, 8'h00, 7'd0},
        {2'd1, 4'd0, 8'h45, 7'd79},
        {2'd1, 4'd0, 8'h46, 7'd78},
        {2'd0, 4'd3, 8'h1F, 7'd78},
        {2'd0, 4'd9, 8'h55, 7'd78},
        {2'd0, 4'd1, 8'h81, 7'd78}
    };

    task automatic read_status(output logic [7:0] st);
        host_rd = 1'b1; host_rs = 1'b0;
        #1 st = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic enter_reset();
        logic [7:0] st;
        @(negedge clk);
        rst_in = 1'b1;
        #1 check("R1 busy asynchronous on reset", 64'(busy), 64'd1);
        repeat (4) @(negedge clk);
        check("R6 register defaults in reset", reg_bank, BANK_DEF);
        read_status(st);
        check("R1/R5 status during reset", 64'(st), 64'h80);
    endtask

    // release reset and walk the busy window; optionally hold a host write across it
    task automatic run_init(input bit cross_write);
        logic [7:0] st;
        int busy_err = 0;
        if (cross_write) begin
            host_wr = 1'b1; host_rs = 1'b0; host_idx = 4'd3; host_wdata = 8'h1F;
        end
        sweep_wr_cnt = 0; bad_busy_wr = 0;
        rst_in = 1'b0;
        for (int i = 1; i <= HOLD + 2; i++) begin
            @(negedge clk);
            if (cross_write && i == HOLD / 2) begin
                host_rs = 1'b1; host_wdata = 8'h77;
            end
            if (i == 2)
                check("R3 sweep starts at address 0 with space",
                      {ram_we, ram_addr, ram_wdata}, {1'b1, 7'd0, 8'h20});
            if (i <= HOLD + 1 && busy !== 1'b1) busy_err++;
        end
        check("R2 busy high through hold window", 64'(busy_err), 64'd0);
        check("R2 busy low at end of window", 64'(busy), 64'd0);
        if (cross_write) begin
            check("R10 held write presented in first ready cycle",
                  {ram_we, ram_addr, ram_wdata}, {1'b1, 7'd0, 8'h77});
            @(negedge clk);
            host_wr = 1'b0;
        end
        check("R3 sweep write count", 64'(sweep_wr_cnt), 64'(DEPTH));
        check("R4 no host write reached RAM while busy", 64'(bad_busy_wr), 64'd0);
        check("R4/R6 registers at defaults after init", reg_bank, BANK_DEF);
        read_status(st);
        check("R5/R10 status after init", 64'(st), cross_write ? 64'h01 : 64'h00);
    endtask

    task automatic check_ram_clear(input string req, input logic [7:0] at0);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++)
            if (ram_model[a] !== ((a == 0) ? at0 : 8'h20)) bad++;
        check(req, 64'(bad), 64'd0);
    endtask

    initial begin
        logic [7:0] st;
        for (int a = 0; a < DEPTH; a++) ram_model[a] = 8'hFF;
        #1 rst_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 busy in power-on reset", 64'(busy), 64'd1);
        check("R6 register defaults at power-on", reg_bank, BANK_DEF);

        run_init(1'b1);
        check_ram_clear("R3 all locations space after sweep", 8'h77);

        // table walk of ready-phase host operations
        for (int v = 0; v < 12; v++) begin
            @(negedge clk);
            host_wr = 1'b1; host_rs = VEC[v][20:19] == 2'd1;
            host_idx = VEC[v][18:15]; host_wdata = VEC[v][14:7];
            @(negedge clk);
            host_wr = 1'b0;
            read_status(st);
            check($sformatf("R7/R8 vector %0d address counter", v), 64'(st), {56'd0, 1'b0, VEC[v][6:0]});
        end
        check("R7 register bank after writes (idx 9 ignored)", reg_bank, 64'h000000001F008100);
        check("R8 wrap and direction RAM[0]",  64'(ram_model[0]),  64'h45);
        check("R8 RAM[1]",                     64'(ram_model[1]),  64'h41);
        check("R8 RAM[78]",                    64'(ram_model[78]), 64'h43);
        check("R8 RAM[79]",                    64'(ram_model[79]), 64'h46);
        #1 check("R5 rdata zero without read strobe", 64'(host_rdata), 64'd0);

        // R9: reset during the next sweep, then a clean restart
        enter_reset();
        @(negedge clk);
        rst_in = 1'b0;
        repeat (40) @(negedge clk);
        check("R9 mid-sweep still busy", 64'(busy), 64'd1);
        enter_reset();
        run_init(1'b0);
        check_ram_clear("R9 full sweep after restart", 8'h20);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule